// File: doc/BRIEF.md
# Video FIFO Drain and Overrun Discard Controller

This block sits on the drain side of three video data FIFOs that feed a bus-master write engine. It compares every FIFO occupancy count against two programmable thresholds. A burst may be opened only while all counts leave headroom below the almost-full level, because data keeps arriving while the target is slow to answer. After that it pulls words out for the write engine. The bus engine, the instruction prefetcher and the FIFO storage sit outside the block. Each one is reached through simple strobes.

When a FIFO reaches the full level and the bus is not held, the block does not stall and does not flush. It keeps popping words and drops them as though they had been written, so its byte position inside the line stays exact. If the fill happens after a burst has been committed but before the target answers, it ends that burst as soon as the target answers, raises a sticky slow-target flag and switches to discarding. While discarding it walks through prefetched instructions and then on to the end of the line. For each end-of-line word it drops, it counts a line whose closing instruction is still owed. Back in idle it skips that many end-of-line instructions, which realigns the instruction stream with the video. A parity error on an instruction fetch stops all activity at once and sets a sticky flag.

Top module: `dma_overrun_ctl`

## Requirements
- R1: After reset, every strobe output, `byte_pos`, `lines_skip` and both interrupt flags are 0, and the block is idle.
- R2: `burst_start` (which also takes the instruction) fires in idle only when all of the following hold: `instr_valid`, `bus_gnt`, `lines_skip` zero, no overrun, and every FIFO count strictly below the effective almost-full level, min(`thr_afull`, `thr_full`). `bus_req` is high in idle under the same conditions apart from `bus_gnt`.
- R3: `overrun` is high when any of the three counts is at or above `thr_full`, in planar and in packed mode. An overrun seen in idle moves the block to discard on the next cycle.
- R4: Each `fifo_pop` requires `fifo_avail`. Each pop advances `byte_pos` by 4 (modulo 2^POS_W), and a pop of a word with `fifo_eol` set resets it to 0. In discard every pop is flagged on `pop_drop`.
- R5: If an overrun is seen in the cycle a burst is committed, or while the block waits for the target, the cycle that has `tgt_ack` drives `burst_term`, sets `irq_slow` and enters discard. Otherwise `tgt_ack` starts the transfer.
- R6: In discard with no words left in the current instruction, a valid instruction is taken (no pop in that cycle), unless the current line's end-of-line instruction has already been taken or `lines_skip` is non-zero.
- R7: In discard with no instruction available, words keep being dropped until an end-of-line word is popped.
- R8: A dropped end-of-line word increments `lines_skip` (saturating at 2^LINE_W-1) when the line's end-of-line instruction was not taken. With `bus_gnt` high in that cycle the block returns to idle, otherwise it stays in discard.
- R9: In idle with `lines_skip` non-zero and no overrun, each valid instruction is consumed with `instr_take` and `instr_skip`, and one with `instr_eol` decrements `lines_skip`. No burst starts.
- R10: In discard with words left in the current instruction, `bus_gnt` high and all counts below the effective almost-full level, `burst_start` fires without a pop, and the remaining words are transferred afterwards.
- R11: `par_err` suppresses pop, instruction take and burst start in the same cycle and sets `irq_par`. The block then stays halted, with `bus_req` low, until `irq_par` is cleared.
- R12: When the last word of an instruction is popped in transfer, planar mode (`planar_mode`=1) with `instr_valid` takes the next instruction and keeps transferring without checking the thresholds. Packed mode returns to idle.
- R13: `irq_slow` and `irq_par` are sticky. `irq_clr[0]` clears the slow flag and `irq_clr[1]` clears the parity flag, and a new set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| planar_mode | input | 1 | 1 = planar (three FIFOs drained per plane), 0 = packed |
| thr_full | input | CNT_W | Full threshold |
| thr_afull | input | CNT_W | Almost-full threshold |
| fifo_cnt | input | NUM_FIFO*CNT_W | Occupancy counts, FIFO 0 in the low bits |
| fifo_avail | input | 1 | A word is at the FIFO head |
| fifo_eol | input | 1 | Head word carries the end-of-line marker |
| instr_valid | input | 1 | A prefetched write instruction is waiting |
| instr_len | input | LEN_W | Words in that instruction (at least 1) |
| instr_eol | input | 1 | That instruction closes a line |
| bus_gnt | input | 1 | Bus granted to the write engine |
| tgt_ack | input | 1 | Target answered the committed burst |
| par_err | input | 1 | Parity error on an instruction fetch |
| irq_clr | input | 2 | Write-one-to-clear strobes: bit 0 slow, bit 1 parity |
| bus_req | output | 1 | Bus request |
| burst_start | output | 1 | Open a burst (address phase) |
| burst_term | output | 1 | End the burst right after the target answers |
| fifo_pop | output | 1 | Pop the head word |
| pop_drop | output | 1 | The pop discards its word |
| instr_take | output | 1 | Consume the waiting instruction |
| instr_skip | output | 1 | The consumed instruction is skipped |
| overrun | output | 1 | A FIFO is at or above full |
| byte_pos | output | POS_W | Byte position within the line |
| lines_skip | output | LINE_W | End-of-line instructions still to skip |
| irq_slow | output | 1 | Sticky slow-target flag |
| irq_par | output | 1 | Sticky parity flag |

## Verification
A wrong phase register or a wrong words-left count shows up within one cycle. It appears as an extra or missing `fifo_pop`, `instr_take` or `burst_start`, because these strobes are decoded from state and inputs in the same cycle. A wrong record of the taken end-of-line instruction shows up only at the next dropped end-of-line word, as a wrong value on `lines_skip`. A stale overflow mark shows up at the next `tgt_ack` as a false `burst_term`. The bench compares every output with a behavioural model on every cycle, so each of these divergences is caught in the cycle where it first reaches a port.

// File: rtl/dma_overrun_ctl.sv
module dma_overrun_ctl #(
  parameter int NUM_FIFO   = 3,
  parameter int CNT_W      = 8,
  parameter int LEN_W      = 8,
  parameter int POS_W      = 12,
  parameter int LINE_W     = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      planar_mode,
  input  logic [CNT_W-1:0]          thr_full,
  input  logic [CNT_W-1:0]          thr_afull,
  input  logic [NUM_FIFO*CNT_W-1:0] fifo_cnt,
  input  logic                      fifo_avail,
  input  logic                      fifo_eol,
  input  logic                      instr_valid,
  input  logic [LEN_W-1:0]          instr_len,
  input  logic                      instr_eol,
  input  logic                      bus_gnt,
  input  logic                      tgt_ack,
  input  logic                      par_err,
  input  logic [1:0]                irq_clr,
  output logic                      bus_req,
  output logic                      burst_start,
  output logic                      burst_term,
  output logic                      fifo_pop,
  output logic                      pop_drop,
  output logic                      instr_take,
  output logic                      instr_skip,
  output logic                      overrun,
  output logic [POS_W-1:0]          byte_pos,
  output logic [LINE_W-1:0]         lines_skip,
  output logic                      irq_slow,
  output logic                      irq_par
);

  localparam logic [LINE_W-1:0] SKIP_MAX = {LINE_W{1'b1}};
  localparam logic [POS_W-1:0]  STEP     = POS_W'(WORD_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_XFER, S_DROP, S_HALT} st_t;

  st_t st, nxt;
  logic [LEN_W-1:0] rem;
  logic eol_taken, ovf_seen, set_slow;
  logic [NUM_FIFO-1:0] lt_full, lt_afull;
  logic [CNT_W-1:0] afull_eff;

  assign afull_eff = (thr_afull < thr_full) ? thr_afull : thr_full;

  for (genvar g = 0; g < NUM_FIFO; g++) begin : g_cmp
    assign lt_full[g]  = fifo_cnt[g*CNT_W +: CNT_W] < thr_full;
    assign lt_afull[g] = fifo_cnt[g*CNT_W +: CNT_W] < afull_eff;
  end

  wire ok_afull  = &lt_afull;
  wire have      = rem != '0;
  wire last_word = rem == LEN_W'(1);
  wire skipping  = lines_skip != '0;

  assign overrun  = ~&lt_full;
  assign pop_drop = fifo_pop && (st == S_DROP);

  always_comb begin
    nxt = st;
    bus_req = 1'b0;
    burst_start = 1'b0;
    burst_term = 1'b0;
    fifo_pop = 1'b0;
    instr_take = 1'b0;
    instr_skip = 1'b0;
    set_slow = 1'b0;
    if (par_err) begin
      nxt = S_HALT;
    end else begin
      case (st)
        S_IDLE: begin
          if (overrun) begin
            nxt = S_DROP;
          end else if (skipping) begin
            instr_take = instr_valid;
            instr_skip = instr_valid;
          end else if (instr_valid && ok_afull) begin
            bus_req = 1'b1;
            if (bus_gnt) begin
              burst_start = 1'b1;
              instr_take = 1'b1;
              nxt = S_ADDR;
            end
          end
        end
        S_ADDR: begin
          bus_req = 1'b1;
          if (tgt_ack) begin
            if (ovf_seen || overrun) begin
              burst_term = 1'b1;
              set_slow = 1'b1;
              nxt = S_DROP;
            end else begin
              nxt = S_XFER;
            end
          end
        end
        S_XFER: begin
          bus_req = 1'b1;
          fifo_pop = fifo_avail;
          if (fifo_avail && last_word) begin
            if (planar_mode && instr_valid) instr_take = 1'b1;
            else nxt = S_IDLE;
          end
        end
        S_DROP: begin
          bus_req = 1'b1;
          if (have && bus_gnt && ok_afull) begin
            burst_start = 1'b1;
            nxt = S_ADDR;
          end else if (!have && instr_valid && !eol_taken && !skipping) begin
            instr_take = 1'b1;
          end else begin
            fifo_pop = fifo_avail;
            if (fifo_avail && fifo_eol && bus_gnt) nxt = S_IDLE;
          end
        end
        S_HALT: begin
          if (!irq_par) nxt = S_IDLE;
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rem <= '0;
      eol_taken <= 1'b0;
      ovf_seen <= 1'b0;
      byte_pos <= '0;
      lines_skip <= '0;
      irq_slow <= 1'b0;
      irq_par <= 1'b0;
    end else begin
      st <= nxt;

      if (burst_start) ovf_seen <= 1'b0;
      else if (st == S_ADDR && overrun) ovf_seen <= 1'b1;

      if (par_err) begin
        rem <= '0;
        eol_taken <= 1'b0;
      end else if (instr_take && !instr_skip) begin
        rem <= instr_len;
        eol_taken <= instr_eol;
      end else if (fifo_pop) begin
        if (pop_drop && fifo_eol) rem <= '0;
        else if (have) rem <= rem - LEN_W'(1);
        if (fifo_eol) eol_taken <= 1'b0;
      end

      if (instr_skip && instr_eol)
        lines_skip <= lines_skip - LINE_W'(1);
      else if (pop_drop && fifo_eol && !eol_taken && lines_skip != SKIP_MAX)
        lines_skip <= lines_skip + LINE_W'(1);

      if (fifo_pop) byte_pos <= fifo_eol ? '0 : byte_pos + STEP;

      irq_slow <= set_slow | (irq_slow & ~irq_clr[0]);
      irq_par  <= par_err  | (irq_par  & ~irq_clr[1]);
    end
  end

endmodule

// File: rtl/dma_overrun_ctl_chk.sv
module dma_overrun_ctl_chk #(
  parameter int NUM_FIFO = 3,
  parameter int CNT_W    = 8,
  parameter int LINE_W   = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [CNT_W-1:0]          thr_full,
  input logic [CNT_W-1:0]          thr_afull,
  input logic [NUM_FIFO*CNT_W-1:0] fifo_cnt,
  input logic                      fifo_avail,
  input logic                      bus_gnt,
  input logic                      par_err,
  input logic [1:0]                irq_clr,
  input logic                      burst_start,
  input logic                      burst_term,
  input logic                      fifo_pop,
  input logic                      pop_drop,
  input logic                      instr_take,
  input logic [LINE_W-1:0]         lines_skip,
  input logic                      irq_slow,
  input logic                      irq_par
);

  logic room;
  always_comb begin
    room = 1'b1;
    for (int i = 0; i < NUM_FIFO; i++) begin
      if (fifo_cnt[i*CNT_W +: CNT_W] >= thr_afull || fifo_cnt[i*CNT_W +: CNT_W] >= thr_full)
        room = 1'b0;
    end
  end

  a_r2_start_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> (room && bus_gnt));

  a_r4_pop_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> fifo_avail);

  a_r4_drop_is_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pop_drop |-> fifo_pop);

  a_r11_parity_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> (!fifo_pop && !instr_take && !burst_start));

  a_r11_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> irq_par);

  a_r5_term_flags: assert property (@(posedge clk) disable iff (!rst_n)
    burst_term |=> irq_slow);

  a_r13_slow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_slow && !irq_clr[0]) |=> irq_slow);

  a_r9_no_start_while_skipping: assert property (@(posedge clk) disable iff (!rst_n)
    (lines_skip != '0) |-> !burst_start);

  a_r8_skip_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lines_skip == $past(lines_skip) || lines_skip == $past(lines_skip) + 1
              || lines_skip == $past(lines_skip) - 1));

endmodule

bind dma_overrun_ctl dma_overrun_ctl_chk #(
  .NUM_FIFO(NUM_FIFO), .CNT_W(CNT_W), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_full(thr_full), .thr_afull(thr_afull),
  .fifo_cnt(fifo_cnt), .fifo_avail(fifo_avail), .bus_gnt(bus_gnt),
  .par_err(par_err), .irq_clr(irq_clr), .burst_start(burst_start),
  .burst_term(burst_term), .fifo_pop(fifo_pop), .pop_drop(pop_drop),
  .instr_take(instr_take), .lines_skip(lines_skip), .irq_slow(irq_slow),
  .irq_par(irq_par)
);

// File: tb/dma_overrun_ctl_tb.sv
module dma_overrun_ctl_tb;
  localparam int CW = 8, LW = 8, PW = 12, KW = 4;
  localparam int KMAX = (1 << KW) - 1;
  localparam int IDLE = 0, ADDR = 1, XFER = 2, DROP = 3, HALT = 4;

  logic clk = 0, rst_n = 0;
  logic planar_mode = 0;
  logic [CW-1:0] thr_full = 12, thr_afull = 8;
  logic [3*CW-1:0] fifo_cnt;
  logic fifo_avail = 1, fifo_eol = 0, instr_valid = 0, instr_eol = 0;
  logic [LW-1:0] instr_len = 4;
  logic bus_gnt = 0, tgt_ack = 0, par_err = 0;
  logic [1:0] irq_clr = 0;
  logic bus_req, burst_start, burst_term, fifo_pop, pop_drop, instr_take, instr_skip, overrun;
  logic [PW-1:0] byte_pos;
  logic [KW-1:0] lines_skip;
  logic irq_slow, irq_par;

  int c0 = 2, c1 = 2, c2 = 2;
  assign fifo_cnt = {CW'(c2), CW'(c1), CW'(c0)};

  dma_overrun_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .planar_mode(planar_mode), .thr_full(thr_full),
    .thr_afull(thr_afull), .fifo_cnt(fifo_cnt), .fifo_avail(fifo_avail),
    .fifo_eol(fifo_eol), .instr_valid(instr_valid), .instr_len(instr_len),
    .instr_eol(instr_eol), .bus_gnt(bus_gnt), .tgt_ack(tgt_ack), .par_err(par_err),
    .irq_clr(irq_clr), .bus_req(bus_req), .burst_start(burst_start),
    .burst_term(burst_term), .fifo_pop(fifo_pop), .pop_drop(pop_drop),
    .instr_take(instr_take), .instr_skip(instr_skip), .overrun(overrun),
    .byte_pos(byte_pos), .lines_skip(lines_skip), .irq_slow(irq_slow), .irq_par(irq_par)
  );

  always #4 clk = ~clk;

  int nchk = 0, nerr = 0, ncyc = 0;

  // reference model state
  int ms = IDLE, mrem = 0, mpos = 0, mskip = 0, nx = IDLE;
  bit meolt = 0, movf = 0, mslow = 0, mpar = 0;
  bit e_req, e_start, e_term, e_pop, e_drop, e_take, e_skip, e_ovr, e_setslow;

  function automatic void eval();
    int afe, c[3];
    bit oka;
    c[0] = c0; c[1] = c1; c[2] = c2;
    afe = (thr_afull < thr_full) ? int'(thr_afull) : int'(thr_full);
    oka = 1; e_ovr = 0;
    for (int i = 0; i < 3; i++) begin
      if (c[i] >= int'(thr_full)) e_ovr = 1;
      if (c[i] >= afe) oka = 0;
    end
    {e_req, e_start, e_term, e_pop, e_take, e_skip, e_setslow} = '0;
    nx = ms;
    if (par_err) nx = HALT;
    else if (ms == IDLE) begin
      if (e_ovr) nx = DROP;
      else if (mskip > 0) begin e_take = instr_valid; e_skip = instr_valid; end
      else if (instr_valid && oka) begin
        e_req = 1;
        if (bus_gnt) begin e_start = 1; e_take = 1; nx = ADDR; end
      end
    end else if (ms == ADDR) begin
      e_req = 1;
      if (tgt_ack) begin
        if (movf || e_ovr) begin e_term = 1; e_setslow = 1; nx = DROP; end
        else nx = XFER;
      end
    end else if (ms == XFER) begin
      e_req = 1; e_pop = fifo_avail;
      if (fifo_avail && mrem == 1) begin
        if (planar_mode && instr_valid) e_take = 1; else nx = IDLE;
      end
    end else if (ms == DROP) begin
      e_req = 1;
      if (mrem > 0 && bus_gnt && oka) begin e_start = 1; nx = ADDR; end
      else if (mrem == 0 && instr_valid && !meolt && mskip == 0) e_take = 1;
      else begin
        e_pop = fifo_avail;
        if (fifo_avail && fifo_eol && bus_gnt) nx = IDLE;
      end
    end else if (!mpar) nx = IDLE;
    e_drop = e_pop && ms == DROP;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = IDLE; mrem = 0; mpos = 0; mskip = 0; meolt = 0; movf = 0; mslow = 0; mpar = 0;
    end else begin
      bit old_eolt;
      eval();
      old_eolt = meolt;
      if (e_start) movf = 0; else if (ms == ADDR && e_ovr) movf = 1;
      if (par_err) begin mrem = 0; meolt = 0; end
      else if (e_take && !e_skip) begin mrem = instr_len; meolt = instr_eol; end
      else if (e_pop) begin
        if (e_drop && fifo_eol) mrem = 0; else if (mrem > 0) mrem = mrem - 1;
        if (fifo_eol) meolt = 0;
      end
      if (e_skip && instr_eol) mskip = mskip - 1;
      else if (e_drop && fifo_eol && !old_eolt && mskip < KMAX) mskip = mskip + 1;
      if (e_pop) mpos = fifo_eol ? 0 : (mpos + 4) % (1 << PW);
      mslow = e_setslow || (mslow && !irq_clr[0]);
      mpar = par_err || (mpar && !irq_clr[1]);
      ms = nx;
    end
  end

  task automatic ck(string req, string nm, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, nm, act, exp);
    end
  endtask

  task automatic compare_all();
    eval();
    ck("R2", "bus_req", bus_req, e_req);
    ck("R2 R10", "burst_start", burst_start, e_start);
    ck("R5", "burst_term", burst_term, e_term);
    ck("R4", "fifo_pop", fifo_pop, e_pop);
    ck("R4 R7", "pop_drop", pop_drop, e_drop);
    ck("R6 R12", "instr_take", instr_take, e_take);
    ck("R9", "instr_skip", instr_skip, e_skip);
    ck("R3", "overrun", overrun, e_ovr);
    ck("R4", "byte_pos", byte_pos, mpos);
    ck("R8", "lines_skip", lines_skip, mskip);
    ck("R13", "irq_slow", irq_slow, mslow);
    ck("R11", "irq_par", irq_par, mpar);
  endtask

  task automatic look(); #1; endtask
  task automatic go(); compare_all(); @(negedge clk); endtask
  task automatic cyc(); look(); go(); endtask
  task automatic cnt(int a, int b, int c); c0 = a; c1 = b; c2 = c; endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 100000) begin
      nerr++;
      $display("FAIL watchdog: actual=%0d cycles expected=run to end", ncyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    look();
    // R1 reset state
    ck("R1", "outputs", {bus_req, burst_start, burst_term, fifo_pop, instr_take, instr_skip, irq_slow, irq_par}, 0);
    ck("R1", "byte_pos", byte_pos, 0);
    ck("R1", "lines_skip", lines_skip, 0);
    go();

    // packed burst of 3 words, last carries end of line
    instr_valid = 1; instr_len = 3; instr_eol = 1; bus_gnt = 1; cyc();
    instr_valid = 0; cyc();
    tgt_ack = 1; cyc();
    tgt_ack = 0; cyc(); cyc();
    fifo_eol = 1; cyc(); fifo_eol = 0;

    // R2: count at almost-full blocks the start
    cnt(8, 2, 2); instr_valid = 1; instr_len = 2; instr_eol = 1;
    look();
    ck("R2", "burst_start at afull", burst_start, 0);
    ck("R2", "bus_req at afull", bus_req, 0);
    go();
    // R2: almost-full above full is limited by full
    thr_afull = 20; thr_full = 9; cnt(8, 2, 2);
    look(); ck("R2", "start with clamped afull", burst_start, 1); go();
    instr_valid = 0; tgt_ack = 1; cyc(); tgt_ack = 0; cyc();
    fifo_eol = 1; cyc(); fifo_eol = 0;
    thr_afull = 8; thr_full = 12; cnt(2, 2, 2); bus_gnt = 0; cyc();

    // R3 overrun in idle goes to discard
    cnt(2, 12, 2);
    look(); ck("R3", "overrun", overrun, 1); go();
    cnt(2, 2, 2);
    look(); ck("R7", "drop without instruction", pop_drop, 1); go();
    cyc();
    instr_valid = 1; instr_len = 2; instr_eol = 0;
    look(); ck("R6", "take in discard", instr_take, 1); ck("R6", "no pop on take", fifo_pop, 0); go();
    instr_valid = 0; cyc(); cyc();
    fifo_eol = 1; cyc(); fifo_eol = 0;
    for (int l = 0; l < 2; l++) begin cyc(); fifo_eol = 1; cyc(); fifo_eol = 0; end
    bus_gnt = 1; fifo_eol = 1; cyc(); fifo_eol = 0; bus_gnt = 0;
    look(); ck("R8", "lines owed", lines_skip, 4); go();
    instr_valid = 1; instr_len = 3;
    for (int i = 0; i < 10; i++) begin
      instr_eol = (i % 2) != 0;
      look(); ck("R9", "skip strobe", instr_skip, (i < 8) ? 1 : 0); go();
    end
    instr_valid = 0; instr_eol = 0;

    // R5 slow target, then R10 resume mid-line
    instr_valid = 1; instr_len = 4; instr_eol = 1; bus_gnt = 1; cyc();
    instr_valid = 0; cnt(2, 2, 12); cyc();
    cnt(2, 2, 2); tgt_ack = 1;
    look(); ck("R5", "burst_term", burst_term, 1); go();
    tgt_ack = 0;
    look(); ck("R10", "resume start", burst_start, 1); ck("R13", "slow set", irq_slow, 1); go();
    tgt_ack = 1; irq_clr = 1; cyc(); tgt_ack = 0; irq_clr = 0;
    look(); ck("R13", "slow cleared", irq_slow, 0); go();
    cyc(); cyc(); fifo_eol = 1; cyc(); fifo_eol = 0;

    // R11 parity
    instr_valid = 1; instr_len = 3; instr_eol = 1; cyc();
    instr_valid = 0; tgt_ack = 1; cyc(); tgt_ack = 0;
    par_err = 1;
    look(); ck("R11", "pop suppressed", fifo_pop, 0); go();
    par_err = 0;
    look(); ck("R11", "irq_par", irq_par, 1); ck("R11", "no request halted", bus_req, 0); go();
    instr_valid = 1; cyc();
    irq_clr = 2; cyc(); irq_clr = 0; instr_valid = 0; cyc(); cyc();

    // R12 planar chaining
    planar_mode = 1; instr_valid = 1; instr_len = 2; instr_eol = 0; cyc();
    instr_eol = 1; cyc();
    tgt_ack = 1; cyc(); tgt_ack = 0; cnt(9, 2, 2); cyc();
    look(); ck("R12", "chained take", instr_take, 1); ck("R12", "no new start", burst_start, 0); go();
    instr_valid = 0; cyc(); fifo_eol = 1; cyc(); fifo_eol = 0; planar_mode = 0; cnt(2, 2, 2); cyc();

    // R8 saturation
    bus_gnt = 0; cnt(12, 2, 2); cyc();
    for (int l = 0; l < 17; l++) begin cyc(); fifo_eol = 1; cyc(); fifo_eol = 0; end
    look(); ck("R8", "saturated", lines_skip, KMAX); go();
    bus_gnt = 1; fifo_eol = 1; cnt(2, 2, 2); cyc(); fifo_eol = 0; bus_gnt = 0;
    instr_valid = 1; instr_eol = 1;
    for (int i = 0; i < 16; i++) cyc();
    instr_valid = 0;

    // mixed stimulus
    for (int i = 0; i < 3000; i++) begin
      cnt($urandom_range(0, 13), $urandom_range(0, 13), $urandom_range(0, 13));
      fifo_avail = ($urandom_range(0, 7) != 0);
      fifo_eol = ($urandom_range(0, 5) == 0);
      instr_valid = $urandom_range(0, 1);
      instr_len = LW'($urandom_range(1, 5));
      instr_eol = $urandom_range(0, 1);
      bus_gnt = $urandom_range(0, 1);
      tgt_ack = ($urandom_range(0, 2) == 0);
      par_err = ($urandom_range(0, 99) == 0);
      irq_clr = 2'($urandom_range(0, 3));
      planar_mode = (i >= 1500);
      cyc();
    end
    finish_run();
  end
endmodule